// File: doc/BRIEF.md
# Adder-Based Arithmetic Logic Unit

This block is a combinational arithmetic logic unit whose every function, arithmetic and logic alike, comes out of one chain of full adders. Two operands enter the chain. A mode bit picks arithmetic or logic, and a two-bit function select shapes the adder's inputs in each bit. In arithmetic mode the carry input serves as a fourth opcode bit, so the unit offers eight arithmetic functions. In logic mode the stage carries are held at zero and each bit's adder inputs are rewritten, so the sum bits give OR, XOR, AND or complement without a separate logic path.

The datapath is a cascade of identical one-bit slices linked through their carries. The operand width is a parameter, and widening the unit only adds slices. A parameter also chooses how each slice's full adder is described. The carry output is the most significant slice's carry in arithmetic mode and is held low in logic mode.

Top module: `arith_logic_unit`

## Requirements
- R1: With mode_logic=0 and fn_sel=00, result is opa when carry_in=0 and opa+1 (mod 2^WIDTH) when carry_in=1.
- R2: With mode_logic=0 and fn_sel=01, result is opa+opb+carry_in (mod 2^WIDTH).
- R3: With mode_logic=0 and fn_sel=10, result is opa plus the one's complement of opb plus carry_in (mod 2^WIDTH): opa-opb-1 when carry_in=0 and opa-opb when carry_in=1.
- R4: With mode_logic=0 and fn_sel=11, all ones are added to opa plus carry_in: result is opa-1 (mod 2^WIDTH) when carry_in=0 and opa when carry_in=1.
- R5: In arithmetic mode, carry_out is bit WIDTH of the (WIDTH+1)-bit sum opa + Y + carry_in, where Y is 0, opb, ~opb or all ones for fn_sel 00, 01, 10, 11.
- R6: With mode_logic=1, result is opa|opb for fn_sel=00, opa^opb for 01, opa&opb for 10 and ~opa for 11, and carry_in has no effect on it.
- R7: With mode_logic=1, carry_out is 0 whatever the operands, fn_sel and carry_in are.
- R8: The unit is WIDTH identical slices chained through their carries; WIDTH below 1 stops elaboration, and both full-adder forms give the same results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| mode_logic | input | 1 | 0 selects arithmetic functions, 1 selects logic functions |
| fn_sel | input | 2 | Function select within the mode |
| carry_in | input | 1 | Carry into the least significant slice; opcode bit in arithmetic mode |
| result | output | WIDTH | Function result |
| carry_out | output | 1 | Carry from the most significant slice, held 0 in logic mode |

## Verification
The assertions inside the slices and the top compare the outputs with a plain arithmetic or bitwise reference. They assume the inputs have settled to known two-state values whenever they are evaluated. The reference itself depends only on the inputs, because the block holds no state. The bench drives all inputs together at one point in the clock cycle and reads the outputs a full cycle later, so no check sees a half-updated input set. It sweeps every operand pair for every mode, function select and carry input at the default width of 4.

// File: rtl/alu_pkg.sv
package alu_pkg;

   // Function-select codes. In arithmetic mode a code picks the adder's second input;
   // in logic mode the same code picks the bitwise operation.
   typedef enum logic [1:0] {
      FN_ZERO_OR   = 2'b00,  // arith: Y = 0      | logic: OR
      FN_B_XOR     = 2'b01,  // arith: Y = B      | logic: XOR
      FN_NB_AND    = 2'b10,  // arith: Y = ~B     | logic: AND
      FN_ONES_NOTA = 2'b11   // arith: Y = all 1s | logic: NOT A
   } fn_code_e;

   // Full-adder description variants
   localparam int FA_GATES  = 0;
   localparam int FA_ARITH  = 1;

   // Per-bit adder input bundle
   typedef struct packed {
      logic x;
      logic y;
      logic z;
   } fa_in_t;

endpackage

// File: rtl/alu_operand_shaper.sv
module alu_operand_shaper
   import alu_pkg::*;
(
   input  logic   a_bit,
   input  logic   b_bit,
   input  logic   c_bit,
   input  logic   mode_logic,
   input  logic [1:0] fn_sel,
   output fa_in_t fa_in
);

   fn_code_e code;
   logic     or_boost;
   logic     and_boost;

   assign code = fn_code_e'(fn_sel);

   // Extra terms on the first adder input that turn XOR into OR / AND
   assign or_boost  = mode_logic & (code == FN_ZERO_OR) & b_bit;
   assign and_boost = mode_logic & (code == FN_NB_AND)  & ~b_bit;

   always_comb begin
      fa_in.x = a_bit | or_boost | and_boost;
      unique case (code)
         FN_ZERO_OR   : fa_in.y = 1'b0;
         FN_B_XOR     : fa_in.y = b_bit;
         FN_NB_AND    : fa_in.y = ~b_bit;
         FN_ONES_NOTA : fa_in.y = 1'b1;
         default      : fa_in.y = 1'b0;
      endcase
      // Carries are inhibited in logic mode
      fa_in.z = c_bit & ~mode_logic;
   end

   // R7
   always_comb begin
      carry_inhibit_chk: assert (!(mode_logic && fa_in.z))
         else $error("stage carry not inhibited in logic mode");
   end

endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder
   import alu_pkg::*;
#(
   parameter int FA_FORM = FA_GATES
)(
   input  fa_in_t fa_in,
   output logic   sum,
   output logic   cout
);

   generate
      if (FA_FORM == FA_GATES) begin : g_gates
         logic half;
         assign half = fa_in.x ^ fa_in.y;
         assign sum  = half ^ fa_in.z;
         assign cout = (fa_in.x & fa_in.y) | (half & fa_in.z);
      end else if (FA_FORM == FA_ARITH) begin : g_arith
         logic [1:0] total;
         assign total = {1'b0, fa_in.x} + {1'b0, fa_in.y} + {1'b0, fa_in.z};
         assign sum   = total[0];
         assign cout  = total[1];
      end else begin : g_bad
         $error("alu_full_adder: FA_FORM must be FA_GATES or FA_ARITH");
      end
   endgenerate

   // R8
   always_comb begin
      fa_count_chk: assert ({1'b0, cout, sum} ==
                            ({2'b0, fa_in.x} + {2'b0, fa_in.y} + {2'b0, fa_in.z}))
         else $error("full adder sum/carry mismatch");
   end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
   import alu_pkg::*;
#(
   parameter int FA_FORM = FA_GATES
)(
   input  logic       a_bit,
   input  logic       b_bit,
   input  logic       c_in,
   input  logic       mode_logic,
   input  logic [1:0] fn_sel,
   output logic       f_bit,
   output logic       c_out
);

   fa_in_t fa_in;

   alu_operand_shaper i_shaper (
      .a_bit      (a_bit),
      .b_bit      (b_bit),
      .c_bit      (c_in),
      .mode_logic (mode_logic),
      .fn_sel     (fn_sel),
      .fa_in      (fa_in)
   );

   alu_full_adder #(
      .FA_FORM (FA_FORM)
   ) i_fa (
      .fa_in (fa_in),
      .sum   (f_bit),
      .cout  (c_out)
   );

   // R6
   always_comb begin
      if (mode_logic) begin
         logic expect_bit;
         unique case (fn_sel)
            2'b00:   expect_bit = a_bit | b_bit;
            2'b01:   expect_bit = a_bit ^ b_bit;
            2'b10:   expect_bit = a_bit & b_bit;
            default: expect_bit = ~a_bit;
         endcase
         slice_logic_chk: assert (f_bit == expect_bit)
            else $error("logic slice output wrong");
      end
   end

endmodule

// File: rtl/arith_logic_unit.sv
module arith_logic_unit
   import alu_pkg::*;
#(
   parameter int WIDTH   = 4,
   parameter int FA_FORM = FA_GATES
)(
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             mode_logic,
   input  logic [1:0]       fn_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   localparam int CHAIN_LEN = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_width_bad
         $error("arith_logic_unit: WIDTH must be at least 1");
      end
      if (FA_FORM != FA_GATES && FA_FORM != FA_ARITH) begin : g_form_bad
         $error("arith_logic_unit: unknown FA_FORM");
      end
   endgenerate

   logic [CHAIN_LEN-1:0] carry;

   assign carry[0] = carry_in;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_slice
         alu_bit_slice #(
            .FA_FORM (FA_FORM)
         ) i_slice (
            .a_bit      (opa[i]),
            .b_bit      (opb[i]),
            .c_in       (carry[i]),
            .mode_logic (mode_logic),
            .fn_sel     (fn_sel),
            .f_bit      (result[i]),
            .c_out      (carry[i+1])
         );
      end
   endgenerate

   // Top carry only has meaning for arithmetic
   assign carry_out = carry[WIDTH] & ~mode_logic;

   // R7
   always_comb begin
      logic_cout_chk: assert (!(mode_logic && carry_out))
         else $error("carry_out set in logic mode");
   end

   // R5
   always_comb begin
      if (!mode_logic) begin
         logic [WIDTH-1:0] y_ref;
         logic [WIDTH:0]   sum_ref;
         unique case (fn_sel)
            2'b00:   y_ref = '0;
            2'b01:   y_ref = opb;
            2'b10:   y_ref = ~opb;
            default: y_ref = '1;
         endcase
         sum_ref = {1'b0, opa} + {1'b0, y_ref} + {{WIDTH{1'b0}}, carry_in};
         arith_sum_chk: assert ({carry_out, result} == sum_ref)
            else $error("arithmetic sum or carry mismatch");
      end
   end

endmodule

// File: tb/test_arith_logic_unit.sv
module test_arith_logic_unit;

   localparam int WIDTH = 4;
   localparam int NVAL  = 1 << WIDTH;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [WIDTH-1:0] opa = '0;
   logic [WIDTH-1:0] opb = '0;
   logic             mode_logic = 1'b0;
   logic [1:0]       fn_sel = 2'b00;
   logic             carry_in = 1'b0;
   logic [WIDTH-1:0] result;
   logic             carry_out;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;

   always #2 clk = ~clk;   // 250 MHz

   arith_logic_unit #(.WIDTH(WIDTH)) i_arith_logic_unit (
      .opa        (opa),
      .opb        (opb),
      .mode_logic (mode_logic),
      .fn_sel     (fn_sel),
      .carry_in   (carry_in),
      .result     (result),
      .carry_out  (carry_out)
   );

   task automatic check(input string req, input int got, input int exp, input string what);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d (m=%0b fn=%0b ci=%0b a=%0d b=%0d)",
                  req, what, got, exp, mode_logic, fn_sel, carry_in, opa, opb);
      end
   endtask

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // All-zero inputs: transfer of zero
      check("R1", int'(result), 0, "idle result");
      check("R5", int'(carry_out), 0, "idle carry");

      for (int m = 0; m < 2; m++) begin
         for (int f = 0; f < 4; f++) begin
            for (int ci = 0; ci < 2; ci++) begin
               for (int a = 0; a < NVAL; a++) begin
                  for (int b = 0; b < NVAL; b++) begin
                     int y;
                     int sum;
                     int exp_r;
                     int exp_c;
                     string req;
                     @(negedge clk);
                     opa        = WIDTH'(a);
                     opb        = WIDTH'(b);
                     mode_logic = m[0];
                     fn_sel     = f[1:0];
                     carry_in   = ci[0];
                     @(negedge clk);
                     if (m == 0) begin
                        case (f)
                           0: begin y = 0;                req = "R1"; end
                           1: begin y = b;                req = "R2"; end
                           2: begin y = (NVAL - 1) - b;   req = "R3"; end
                           default: begin y = NVAL - 1;   req = "R4"; end
                        endcase
                        sum   = a + y + ci;
                        exp_r = sum % NVAL;
                        exp_c = sum / NVAL;
                        check(req, int'(result), exp_r, "arith result");
                        check("R5", int'(carry_out), exp_c, "arith carry");
                     end else begin
                        case (f)
                           0: exp_r = a | b;
                           1: exp_r = a ^ b;
                           2: exp_r = a & b;
                           default: exp_r = (NVAL - 1) - a;
                        endcase
                        check("R6", int'(result), exp_r, "logic result");
                        check("R7", int'(carry_out), 0, "logic carry");
                     end
                  end
               end
            end
         end
      end

      // R3 / R4 named corner points: 0-1 wraps, decrement of zero, A-A
      @(negedge clk);
      opa = '0; opb = WIDTH'(1); mode_logic = 1'b0; fn_sel = 2'b10; carry_in = 1'b1;
      @(negedge clk);
      check("R3", int'(result), NVAL - 1, "0-1 wrap");
      check("R5", int'(carry_out), 0, "0-1 borrow carry");
      opa = '0; fn_sel = 2'b11; carry_in = 1'b0;
      @(negedge clk);
      check("R4", int'(result), NVAL - 1, "decrement zero");
      check("R5", int'(carry_out), 0, "decrement zero carry");
      // R8: slice chain carries all the way across
      opa = '1; opb = WIDTH'(1); fn_sel = 2'b01;
      @(negedge clk);
      check("R8", int'(result), 0, "full ripple result");
      check("R8", int'(carry_out), 1, "full ripple carry");
      // R6 / R7: AND with zero operand where slice carries would be high
      opa = '1; opb = '0; mode_logic = 1'b1; fn_sel = 2'b10; carry_in = 1'b1;
      @(negedge clk);
      check("R6", int'(result), 0, "AND with zero");
      check("R7", int'(carry_out), 0, "AND carry gated");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule